// File: doc/BRIEF.md
# Multiplexed-Address Parallel Flash Bus Front-End

This block sits between the pins of a parallel flash device, as driven by an off-board programmer, and the storage array behind them. The address comes in two halves over eleven shared pins: a falling edge on the row/column strobe captures the low half, and a rising edge captures the high half. The block joins the halves into the internal byte address and presents its low nineteen bits to a synchronous array with one cycle of read latency.

The device has no chip-enable pin. The output-enable pin, the write-enable pin and the reset pin alone set the bus mode: read, write, idle (output disabled or standby), no-operation, or reset. In a read, the block drives the data bus, and it reports through an enable output whether the bus is driven or left at high impedance. In a write, the block captures the data pins when write-enable rises. It then hands the byte and the address to a command decoder outside this block as a one-cycle pulse. With the identification input high, a read returns one of two fixed identification bytes in place of array data.

All pins are sampled on the rising edge of the system clock. Strobe and write-enable edges are found by comparing each sample with the one before it.

Top module: `mux_addr_flash_if`

## Requirements
- R1: While the synchronous reset `rst` is high and on the cycle after it, `dout_en` and `wr_valid` are 0 and `mem_addr` is 0.
- R2: On a clock edge where `rc_strobe` is sampled 0 after being sampled 1, and `rst_pin_n` is 1, `addr_pins` are latched into internal address bits 10:0. `mem_addr[10:0]` shows them from the next cycle.
- R3: On a clock edge where `rc_strobe` is sampled 1 after being sampled 0, and `rst_pin_n` is 1, `addr_pins` are latched into internal address bits 21:11. `mem_addr[18:11]` shows bits 7:0 of that capture from the next cycle.
- R4: Without a strobe edge, both latched halves hold their values whatever `addr_pins` do.
- R5: `mem_addr` is internal address bits 18:0. Internal bits 21:19 (`addr_pins[10:8]` during the column capture) change neither `mem_addr` nor the read data.
- R6: A read is `rst_pin_n`=1, `oe_n`=0, `we_n`=1. `dout_en` is 0 after the first edge of a read and 1 after the second. It then carries the array byte at `mem_addr`, which the array returns one cycle after it is addressed. `dout_en` drops one edge after the read ends.
- R7: Idle (`oe_n`=1, `we_n`=1) and no-operation (`oe_n`=0, `we_n`=0) keep `dout_en` at 0. A `we_n` rise that ends a no-operation produces no write pulse.
- R8: A write is `we_n`=0 with `oe_n`=1 and `rst_pin_n`=1. When `we_n` rises from a write into idle, `wr_valid` is 1 for exactly the next cycle. `wr_data` is `din` sampled at that edge and `wr_addr` is `mem_addr`.
- R9: `rst_pin_n`=0 forces `dout_en` to 0 from the next cycle and clears both address halves to 0. It also cancels a write in progress, so a later `we_n` rise gives no pulse.
- R10: With `id_mode`=1, a read returns `MFR_ID` (default 8'h37) when internal address bit 0 is 0 and `DEV_ID` (default 8'hB4) when it is 1. Internal address bits 21:1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_pins | input | 11 | Shared row/column address pins |
| rc_strobe | input | 1 | Row/column strobe: falling edge captures row, rising edge captures column |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rst_pin_n | input | 1 | Device reset pin, active low |
| id_mode | input | 1 | Return identification bytes on read |
| din | input | 8 | Data pins, input side |
| dout | output | 8 | Data pins, output side |
| dout_en | output | 1 | 1 drives `dout` onto the pins, 0 means high impedance |
| mem_addr | output | 19 | Array byte address |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_addr` |
| wr_valid | output | 1 | One-cycle write strobe to the command decoder |
| wr_addr | output | 19 | Address of the write |
| wr_data | output | 8 | Data captured at the write-enable rise |

## Verification
The bench targets the edge choice of the strobe. A design that latched the row on the rising edge, or the column on the falling edge, would put the halves in swapped places, and the array reads would return the wrong bytes. It checks that the upper column bits are masked, that the halves hold while the pins wander, and that the read path has exactly two cycles of latency. A pipeline one stage short or long shows up as a wrong `dout_en` on those cycles. It also checks that a write-enable rise out of a no-operation, or after the reset pin, sends nothing to the decoder, and that identification reads follow only address bit 0; a design that decoded more bits would return the wrong ID byte.

// File: rtl/mfab_pkg.sv
`timescale 1ns/1ps
package mfab_pkg;

    typedef enum logic [2:0] {
        BUS_RESET,
        BUS_READ,
        BUS_WRITE,
        BUS_IDLE,
        BUS_NOP
    } bus_mode_e;

    // Pin-level mode decode; no chip enable exists, so three pins decide.
    function automatic bus_mode_e decode_mode(input logic rst_n_pin,
                                              input logic oe_n_pin,
                                              input logic we_n_pin);
        if (!rst_n_pin)                   return BUS_RESET;
        else if (!oe_n_pin &&  we_n_pin)  return BUS_READ;
        else if ( oe_n_pin && !we_n_pin)  return BUS_WRITE;
        else if ( oe_n_pin &&  we_n_pin)  return BUS_IDLE;
        else                              return BUS_NOP;
    endfunction

    // Identification byte select: only the lowest address bit matters.
    function automatic logic [7:0] pick_id(input logic sel,
                                           input logic [7:0] mfr,
                                           input logic [7:0] dev);
        return sel ? dev : mfr;
    endfunction

endpackage

// File: rtl/mfab_addr_latch.sv
`timescale 1ns/1ps
module mfab_addr_latch #(
    parameter int PIN_W  = 11,
    parameter int ARR_AW = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rc_strobe,
    input  logic [PIN_W-1:0]  addr_pins,
    output logic [ARR_AW-1:0] addr
);
    localparam int COL_KEEP = ARR_AW - PIN_W;

    logic rc_q;
    logic fall_edge, rise_edge;

    always_ff @(posedge clk) begin
        if (rst) rc_q <= 1'b1;
        else     rc_q <= rc_strobe;
    end

    assign fall_edge = rc_q & ~rc_strobe;
    assign rise_edge = ~rc_q & rc_strobe;

    // Half 0 is the row (falling edge), half 1 the column (rising edge);
    // the column keeps only the bits the array can address.
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int LO = (h == 0) ? 0 : PIN_W;
        localparam int W  = (h == 0) ? PIN_W : COL_KEEP;
        logic take;
        logic [W-1:0] half_q;

        assign take = (h == 0) ? fall_edge : rise_edge;

        always_ff @(posedge clk) begin
            if (rst || clr)  half_q <= '0;
            else if (take)   half_q <= addr_pins[W-1:0];
        end

        assign addr[LO +: W] = half_q;
    end
endmodule

// File: rtl/mfab_rd_path.sv
`timescale 1ns/1ps
module mfab_rd_path #(
    parameter int         DW     = 8,
    parameter logic [7:0] MFR_ID = 8'h37,
    parameter logic [7:0] DEV_ID = 8'hB4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mfab_pkg::bus_mode_e  mode,
    input  logic                 id_mode,
    input  logic                 addr_lsb,
    input  logic [DW-1:0]        mem_rdata,
    output logic [DW-1:0]        dout,
    output logic                 dout_en
);
    import mfab_pkg::*;

    logic rd_q;
    logic is_rd;

    assign is_rd = (mode == BUS_READ);

    // Stage 1 waits for the array; stage 2 drives the pins.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            rd_q    <= is_rd;
            dout_en <= rd_q & is_rd;
            if (id_mode) dout <= DW'(pick_id(addr_lsb, MFR_ID, DEV_ID));
            else         dout <= mem_rdata;
        end
    end
endmodule

// File: rtl/mfab_wr_capture.sv
`timescale 1ns/1ps
module mfab_wr_capture #(
    parameter int ARR_AW = 19,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mfab_pkg::bus_mode_e  mode,
    input  logic [ARR_AW-1:0]    addr,
    input  logic [DW-1:0]        din,
    output logic                 wr_valid,
    output logic [ARR_AW-1:0]    wr_addr,
    output logic [DW-1:0]        wr_data
);
    import mfab_pkg::*;

    typedef struct packed {
        logic [ARR_AW-1:0] a;
        logic [DW-1:0]     d;
    } wr_evt_t;

    logic    armed_q;
    logic    fire;
    wr_evt_t evt_q;

    // A write-enable rise out of a write lands in idle with the arm set.
    assign fire = armed_q && (mode == BUS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            wr_valid <= 1'b0;
            evt_q    <= '0;
        end else begin
            armed_q  <= (mode == BUS_WRITE);
            wr_valid <= fire;
            if (fire) evt_q <= '{a: addr, d: din};
        end
    end

    assign wr_addr = evt_q.a;
    assign wr_data = evt_q.d;
endmodule

// File: rtl/mux_addr_flash_if.sv
`timescale 1ns/1ps
module mux_addr_flash_if #(
    parameter int         PIN_W  = 11,
    parameter int         ARR_AW = 19,
    parameter int         DW     = 8,
    parameter logic [7:0] MFR_ID = 8'h37,
    parameter logic [7:0] DEV_ID = 8'hB4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic              rc_strobe,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rst_pin_n,
    input  logic              id_mode,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_en,
    output logic [ARR_AW-1:0] mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              wr_valid,
    output logic [ARR_AW-1:0] wr_addr,
    output logic [DW-1:0]     wr_data
);
    import mfab_pkg::*;

    bus_mode_e mode;

    assign mode = decode_mode(rst_pin_n, oe_n, we_n);

    mfab_addr_latch #(.PIN_W(PIN_W), .ARR_AW(ARR_AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .clr       (mode == BUS_RESET),
        .rc_strobe (rc_strobe),
        .addr_pins (addr_pins),
        .addr      (mem_addr)
    );

    mfab_rd_path #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .id_mode   (id_mode),
        .addr_lsb  (mem_addr[0]),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    mfab_wr_capture #(.ARR_AW(ARR_AW), .DW(DW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .addr     (mem_addr),
        .din      (din),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );
endmodule

// File: rtl/mux_addr_flash_if_chk.sv
`timescale 1ns/1ps
module mux_addr_flash_if_chk #(
    parameter int PIN_W  = 11,
    parameter int ARR_AW = 19
) (
    input logic              clk,
    input logic              rst,
    input logic [PIN_W-1:0]  addr_pins,
    input logic              rc_strobe,
    input logic              oe_n,
    input logic              we_n,
    input logic              rst_pin_n,
    input logic              dout_en,
    input logic [ARR_AW-1:0] mem_addr,
    input logic              wr_valid
);
    // R2
    row_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rc_strobe) && rst_pin_n) |=> mem_addr[PIN_W-1:0] == $past(addr_pins));

    // R3
    col_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rc_strobe) && rst_pin_n) |=>
            mem_addr[ARR_AW-1:PIN_W] == $past(addr_pins[ARR_AW-PIN_W-1:0]));

    // R6
    drive_only_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> ($past(!oe_n) && $past(we_n) && $past(rst_pin_n)));

    // R9
    reset_pin_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> !dout_en);

    // R8
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R8
    wr_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(we_n) && $past(oe_n) && !$past(we_n, 2)));
endmodule

bind mux_addr_flash_if mux_addr_flash_if_chk #(.PIN_W(PIN_W), .ARR_AW(ARR_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_pins (addr_pins),
    .rc_strobe (rc_strobe),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .rst_pin_n (rst_pin_n),
    .dout_en   (dout_en),
    .mem_addr  (mem_addr),
    .wr_valid  (wr_valid)
);

// File: tb/mux_addr_flash_if_tb.sv
`timescale 1ns/1ps
module mux_addr_flash_if_tb;
    localparam logic [7:0] MFR = 8'h37;
    localparam logic [7:0] DEV = 8'hB4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] addr_pins = '0;
    logic        rc_strobe = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic        rst_pin_n = 1'b1;
    logic        id_mode = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic [18:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        wr_valid;
    logic [18:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mux_addr_flash_if u_dut (
        .clk(clk), .rst(rst), .addr_pins(addr_pins), .rc_strobe(rc_strobe),
        .oe_n(oe_n), .we_n(we_n), .rst_pin_n(rst_pin_n), .id_mode(id_mode),
        .din(din), .dout(dout), .dout_en(dout_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    function automatic logic [7:0] arr_byte(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] id_byte(input logic [21:0] a);
        return a[0] ? DEV : MFR;
    endfunction

    // Array model with one cycle of read latency.
    always @(posedge clk) mem_rdata <= arr_byte(mem_addr);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_addr(input logic [21:0] a);
        addr_pins = a[10:0];
        rc_strobe = 1'b0;
        tick();
        addr_pins = a[21:11];
        rc_strobe = 1'b1;
        tick();
    endtask

    task automatic do_read(input logic [21:0] a, input logic idm);
        load_addr(a);
        chk("R2 row half", {13'b0, mem_addr[10:0]}, {21'b0, a[10:0]});
        chk("R3 col half", {24'b0, mem_addr[18:11]}, {24'b0, a[18:11]});
        id_mode = idm;
        oe_n = 1'b0;
        tick();
        chk("R6 latency first edge", {31'b0, dout_en}, 32'd0);
        tick();
        chk("R6 drive second edge", {31'b0, dout_en}, 32'd1);
        if (idm) chk("R10 id byte", {24'b0, dout}, {24'b0, id_byte(a)});
        else     chk("R6 array byte", {24'b0, dout}, {24'b0, arr_byte(a[18:0])});
        oe_n = 1'b1;
        tick();
        chk("R7 idle hi-z", {31'b0, dout_en}, 32'd0);
        id_mode = 1'b0;
    endtask

    task automatic do_write(input logic [21:0] a, input logic [7:0] d);
        load_addr(a);
        din = d;
        we_n = 1'b0;
        tick();
        tick();
        chk("R8 no pulse while low", {31'b0, wr_valid}, 32'd0);
        chk("R7 write hi-z", {31'b0, dout_en}, 32'd0);
        we_n = 1'b1;
        tick();
        chk("R8 pulse", {31'b0, wr_valid}, 32'd1);
        chk("R8 addr", {13'b0, wr_addr}, {13'b0, a[18:0]});
        chk("R8 data", {24'b0, wr_data}, {24'b0, d});
        din = ~d;
        tick();
        chk("R8 one cycle", {31'b0, wr_valid}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [21:0] a;
        logic [18:0] held;
        void'($urandom(32'd4242));
        tick(); tick();
        chk("R1 reset dout_en", {31'b0, dout_en}, 32'd0);
        chk("R1 reset wr_valid", {31'b0, wr_valid}, 32'd0);
        chk("R1 reset mem_addr", {13'b0, mem_addr}, 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 after reset", {13'b0, mem_addr}, 32'd0);

        // Directed reads and writes
        do_read(22'h3FFFFF, 1'b0);
        do_read(22'h000001, 1'b0);
        do_write(22'h12345, 8'hA5);

        // R4: pins wander without strobe edges
        load_addr(22'h0ABCDE);
        held = mem_addr;
        for (int i = 0; i < 4; i++) begin
            addr_pins = 11'($urandom);
            tick();
        end
        chk("R4 hold", {13'b0, mem_addr}, {13'b0, held});

        // R5: upper column bits ignored
        a = 22'h05A5A5;
        load_addr(a);
        held = mem_addr;
        load_addr(a | 22'h380000);
        chk("R5 upper bits masked", {13'b0, mem_addr}, {13'b0, held});
        do_read(a | 22'h380000, 1'b0);

        // R7: no-operation then we_n rise into read
        load_addr(22'h00777);
        oe_n = 1'b0; we_n = 1'b0;
        tick(); tick(); tick();
        chk("R7 nop hi-z", {31'b0, dout_en}, 32'd0);
        we_n = 1'b1;
        tick();
        chk("R7 no pulse after nop", {31'b0, wr_valid}, 32'd0);
        tick();
        chk("R7 no pulse after nop 2", {31'b0, wr_valid}, 32'd0);
        oe_n = 1'b1;
        tick(); tick();

        // R9: reset pin during read
        load_addr(22'h1F0F0F);
        oe_n = 1'b0;
        tick(); tick();
        chk("R9 pre-check driving", {31'b0, dout_en}, 32'd1);
        rst_pin_n = 1'b0;
        tick();
        chk("R9 hi-z", {31'b0, dout_en}, 32'd0);
        chk("R9 address cleared", {13'b0, mem_addr}, 32'd0);
        rst_pin_n = 1'b1;
        oe_n = 1'b1;
        tick();

        // R9: reset pin cancels a pending write
        load_addr(22'h002222);
        din = 8'h3C;
        we_n = 1'b0;
        tick(); tick();
        rst_pin_n = 1'b0;
        tick();
        rst_pin_n = 1'b1;
        we_n = 1'b1;
        tick();
        chk("R9 write cancelled", {31'b0, wr_valid}, 32'd0);
        tick();
        chk("R9 write cancelled 2", {31'b0, wr_valid}, 32'd0);

        // R10: identification with high bits set
        do_read(22'h3FFFFE, 1'b1);
        do_read(22'h2AAAAB, 1'b1);
        do_read(22'h000000, 1'b1);
        do_read(22'h000001, 1'b1);

        // Random mix
        for (int n = 0; n < 80; n++) begin
            int op;
            op = int'($urandom % 3);
            a = 22'($urandom);
            case (op)
                0: do_read(a, 1'b0);
                1: do_write(a, 8'($urandom));
                default: do_read(a, 1'b1);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule